// File: doc/BRIEF.md
# Self-timed flash byte-program sequencer

This block drives byte writes into an on-chip code-memory array, modelled here as a register array. Each write times itself. A host places an address, a data byte and a command code on the inputs, then raises a program strobe. The block samples the strobe, and a rising edge launches the selected command. An accepted write, chip erase or lock write holds the block busy for a fixed number of cycles, set by `WRITE_CYCLES`. The write is committed when that count ends.

The host can follow progress in two ways. The `ready` output is low for as long as an operation runs. A host can also poll: while a byte write is running, a verify read of the address being written returns the inverse of bit 7 of the new byte. Once the write ends, the stored byte appears in full. Two rules gate programming. A byte that already holds anything other than FFH is refused. Two stored protection flags can block programming and verify reads, and only a chip erase clears them. Signature reads return a fixed identification code. The third byte of that code depends on the `LOW_VOLT` parameter.

The sequencer is a state machine with four states:
- `ST_IDLE`: ready, and accepting commands.
- `ST_PROG`: a byte write is running.
- `ST_ERASE`: a whole-array erase is running.
- `ST_LOCK`: a protection-flag write is running.

The transitions are:
- `ST_IDLE`→`ST_PROG` on an accepted program strobe.
- `ST_IDLE`→`ST_ERASE` on an erase strobe.
- `ST_IDLE`→`ST_LOCK` on a lock strobe.
- Each busy state returns to `ST_IDLE` on the cycle its timer reports its last count.
- A refused or unknown command leaves the machine in `ST_IDLE`.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, `ready` is 1, every array byte reads FFH and both protection flags are clear.
- R2: A rising strobe edge with `mode`=1 (program) starts a write, provided the addressed byte reads FFH and flag 1 is clear. `ready` is 0 from the first clock after the edge for exactly `WRITE_CYCLES` cycles. After that, a verify read (`mode`=0) of the address returns the written byte.
- R3: While a byte write runs, a verify read of the address being written returns the inverse of the new byte's bit 7 on `dout[7]` and 0 on `dout[6:0]`. A verify read of any other address returns the stored array byte.
- R4: A program command aimed at a byte that is not FFH is refused. `ready` stays 1 and the byte keeps its value.
- R5: A strobe with `mode`=2 (chip erase) holds `ready` low for `WRITE_CYCLES` cycles. It then sets every byte to FFH and clears both protection flags.
- R6: With `mode`=3 (signature), address 30H reads 1EH and 31H reads 51H. Address 32H reads FFH when `LOW_VOLT`=0 and 05H when `LOW_VOLT`=1. Every other address reads FFH.
- R7: While flag 1 is set, program commands are refused and `ready` stays 1.
- R8: While flag 2 is set, every verify read returns FFH.
- R9: A strobe edge that arrives while `ready` is 0 is ignored. It changes neither the array nor the running operation.
- R10: A strobe with `mode`=4 (lock write) holds `ready` low for `WRITE_CYCLES` cycles. It then ORs `din[0]` into flag 1 and `din[1]` into flag 2. Only an erase clears a flag.
- R11: Mode codes 5 to 7 start nothing and read FFH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | Byte address for every command |
| din | input | 8 | Byte to program, or protection flags to set |
| mode | input | 3 | Command code: 0 verify, 1 program, 2 erase, 3 signature, 4 lock write |
| strobe | input | 1 | Program strobe; a rising edge launches the command |
| dout | output | 8 | Read data for verify and signature; returns the poll value during a write |
| ready | output | 1 | 1 when idle; 0 while an operation runs |

## Verification
Read results are combinational from `addr`, `mode` and stored state. They are therefore sampled one time step after the inputs change at the falling clock edge. A strobe raised at a falling edge is seen at the next rising edge, so `ready` is first checked low at the following falling edge. The bench then counts falling edges until `ready` returns, and that count must equal `WRITE_CYCLES`. Writes are committed on the last busy edge, so results of a finished operation are read only once `ready` has returned. Polled values are read between the strobe and that point.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [2:0] {
        CMD_VERIFY    = 3'd0,
        CMD_PROGRAM   = 3'd1,
        CMD_ERASE     = 3'd2,
        CMD_SIGNATURE = 3'd3,
        CMD_LOCK      = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_LOCK
    } state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/fp_strobe_edge.sv
module fp_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);
    logic strobe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/fp_write_timer.sv
module fp_write_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (!run)  cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    assign last = run && (cnt_q == LAST_CNT);
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int WRITE_CYCLES = 16,
    parameter bit LOW_VOLT     = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic [2:0]        mode,
    input  logic              strobe,
    output logic [7:0]        dout,
    output logic              ready
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] SIG_A0 = ADDR_W'(8'h30);
    localparam logic [ADDR_W-1:0] SIG_A1 = ADDR_W'(8'h31);
    localparam logic [ADDR_W-1:0] SIG_A2 = ADDR_W'(8'h32);
    localparam logic [7:0] SIG_B2 = LOW_VOLT ? 8'h05 : 8'hFF;

    state_e            state_q, state_d;
    logic              strobe_rise;
    logic              op_done;
    logic [7:0]        mem [DEPTH];
    logic              lock1_q, lock2_q;
    logic [ADDR_W-1:0] pend_addr;
    logic [7:0]        pend_data;
    logic              target_blank;

    fp_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .rise   (strobe_rise)
    );

    fp_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_IDLE),
        .last  (op_done)
    );

    assign target_blank = (mem[addr] == ERASED_BYTE);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe_rise) begin
                    case (mode)
                        CMD_PROGRAM: if (!lock1_q && target_blank) state_d = ST_PROG;
                        CMD_ERASE:   state_d = ST_ERASE;
                        CMD_LOCK:    state_d = ST_LOCK;
                        default:     state_d = ST_IDLE;
                    endcase
                end
            end
            ST_PROG, ST_ERASE, ST_LOCK: if (op_done) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand capture at command acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_addr <= '0;
            pend_data <= ERASED_BYTE;
        end else if (state_q == ST_IDLE && strobe_rise) begin
            pend_addr <= addr;
            pend_data <= din;
        end
    end

    // protection flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock1_q <= 1'b0;
            lock2_q <= 1'b0;
        end else if (op_done && state_q == ST_LOCK) begin
            lock1_q <= lock1_q | pend_data[0];
            lock2_q <= lock2_q | pend_data[1];
        end else if (op_done && state_q == ST_ERASE) begin
            lock1_q <= 1'b0;
            lock2_q <= 1'b0;
        end
    end

    // array, committed on the last busy cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
        end else if (op_done && state_q == ST_PROG) begin
            mem[pend_addr] <= pend_data;
        end else if (op_done && state_q == ST_ERASE) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
        end
    end

    // outputs
    always_comb begin
        ready = (state_q == ST_IDLE);
        dout  = ERASED_BYTE;
        case (mode)
            CMD_VERIFY: begin
                if (lock2_q)
                    dout = ERASED_BYTE;
                else if (state_q == ST_PROG && addr == pend_addr)
                    dout = {~pend_data[7], 7'b0};
                else
                    dout = mem[addr];
            end
            CMD_SIGNATURE: begin
                if      (addr == SIG_A0) dout = 8'h1E;
                else if (addr == SIG_A1) dout = 8'h51;
                else if (addr == SIG_A2) dout = SIG_B2;
                else                     dout = ERASED_BYTE;
            end
            default: dout = ERASED_BYTE;
        endcase
    end
endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk #(
    parameter int ADDR_W       = 8,
    parameter int WRITE_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [2:0]        mode,
    input logic              strobe,
    input logic [7:0]        dout,
    input logic              ready,
    input logic              lock1,
    input logic              lock2,
    input logic              erasing
);
    localparam int LEN_W = $clog2(WRITE_CYCLES + 2);

    logic [LEN_W-1:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_len <= '0;
        else if (!ready) busy_len <= busy_len + 1'b1;
        else             busy_len <= '0;
    end

    // R2
    busy_len_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && busy_len != 0) |-> busy_len == LEN_W'(WRITE_CYCLES));

    // R2
    busy_not_overlong_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> busy_len < LEN_W'(WRITE_CYCLES));

    // R9
    busy_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(strobe));

    // R8
    verify_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock2 && mode == 3'd0) |-> dout == 8'hFF);

    // R6
    sig_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3 && addr == ADDR_W'(8'h30)) |-> dout == 8'h1E);

    // R10
    lock1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock1) |-> $past(erasing));

    // R10
    lock2_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock2) |-> $past(erasing));

    // R11
    unused_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode > 3'd4) |-> dout == 8'hFF);
endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(
    .ADDR_W       (ADDR_W),
    .WRITE_CYCLES (WRITE_CYCLES)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .mode    (mode),
    .strobe  (strobe),
    .dout    (dout),
    .ready   (ready),
    .lock1   (lock1_q),
    .lock2   (lock2_q),
    .erasing (state_q == flash_prog_pkg::ST_ERASE)
);

// File: tb/flash_prog_ctrl_tb_top.sv
module flash_prog_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 12;
    localparam int NVEC       = 21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] din = '0;
    logic [2:0] mode = '0;
    logic       strobe = 1'b0;
    logic [7:0] dout;
    logic       ready;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_prog_ctrl #(.ADDR_W(8), .WRITE_CYCLES(W), .LOW_VOLT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .mode(mode), .strobe(strobe), .dout(dout), .ready(ready)
    );

    // {mode, addr, din, expect}; expect is read data, or bit 0 = accepted
    localparam logic [26:0] VEC [NVEC] = '{
        {3'd3, 8'h30, 8'h00, 8'h1E},   // R6
        {3'd3, 8'h31, 8'h00, 8'h51},   // R6
        {3'd3, 8'h32, 8'h00, 8'hFF},   // R6
        {3'd3, 8'h33, 8'h00, 8'hFF},   // R6
        {3'd0, 8'h10, 8'h00, 8'hFF},   // R1
        {3'd1, 8'h10, 8'hA5, 8'h01},   // R2
        {3'd0, 8'h10, 8'h00, 8'hA5},   // R2
        {3'd1, 8'h10, 8'h00, 8'h00},   // R4
        {3'd0, 8'h10, 8'h00, 8'hA5},   // R4
        {3'd1, 8'h11, 8'h7E, 8'h01},   // R2
        {3'd0, 8'h11, 8'h00, 8'h7E},   // R2
        {3'd4, 8'h00, 8'h01, 8'h01},   // R10
        {3'd1, 8'h12, 8'h55, 8'h00},   // R7
        {3'd0, 8'h12, 8'h00, 8'hFF},   // R7
        {3'd0, 8'h10, 8'h00, 8'hA5},   // R10
        {3'd4, 8'h00, 8'h02, 8'h01},   // R10
        {3'd0, 8'h10, 8'h00, 8'hFF},   // R8
        {3'd2, 8'h00, 8'h00, 8'h01},   // R5
        {3'd0, 8'h10, 8'h00, 8'hFF},   // R5
        {3'd1, 8'h10, 8'h0F, 8'h01},   // R5
        {3'd0, 8'h10, 8'h00, 8'h0F}    // R5
    };
    localparam string TAG [NVEC] = '{
        "R6", "R6", "R6", "R6", "R1", "R2", "R2", "R4", "R4", "R2", "R2",
        "R10", "R7", "R7", "R10", "R10", "R8", "R5", "R5", "R5", "R5"
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_ready(input string tag);
        int n = 0;
        while (!ready && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(n == W, tag, n, W);
    endtask

    task automatic do_cmd(input logic [2:0] m, input logic [7:0] a,
                          input logic [7:0] d, input logic [7:0] e, input string tag);
        @(negedge clk);
        mode = m; addr = a; din = d;
        if (m == 3'd0 || m == 3'd3) begin
            #1;
            check(dout == e, tag, dout, e);
        end else begin
            strobe = 1'b1;
            @(negedge clk);
            strobe = 1'b0;
            if (e[0]) begin
                check(ready == 1'b0, tag, ready, 0);
                wait_ready(tag);
            end else begin
                check(ready == 1'b1, tag, ready, 1);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        check(ready == 1'b1, "R1", ready, 1);
        check(dout == 8'hFF, "R1", dout, 8'hFF);

        for (int i = 0; i < NVEC; i++)
            do_cmd(VEC[i][26:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], TAG[i]);

        // R3 polling during a write, R9 strobe while busy is ignored
        @(negedge clk);
        mode = 3'd1; addr = 8'h20; din = 8'h3C; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0; mode = 3'd0;
        #1;
        check(dout == 8'h80, "R3", dout, 8'h80);
        addr = 8'h10;
        #1;
        check(dout == 8'h0F, "R3", dout, 8'h0F);
        @(negedge clk);
        mode = 3'd1; addr = 8'h21; din = 8'h00; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0; mode = 3'd0; addr = 8'h20;
        #1;
        check(dout == 8'h80, "R3", dout, 8'h80);
        while (!ready) @(negedge clk);
        #1;
        check(dout == 8'h3C, "R3", dout, 8'h3C);
        addr = 8'h21;
        #1;
        check(dout == 8'hFF, "R9", dout, 8'hFF);
        check(ready == 1'b1, "R9", ready, 1);

        // R11 unused mode codes
        do_cmd(3'd5, 8'h22, 8'h00, 8'h00, "R11");
        @(negedge clk);
        mode = 3'd7; addr = 8'h20;
        #1;
        check(dout == 8'hFF, "R11", dout, 8'hFF);
        do_cmd(3'd0, 8'h22, 8'h00, 8'hFF, "R11");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule